// File: doc/BRIEF.md
# Shadow-Tag Associativity Mode Monitor

This block watches the access stream of a first-level cache that can run either direct-mapped or set-associative. It decides when the cache should change regime. A small shadow tag store covers only a sampled subset of the cache sets. That store always models the regime the cache is *not* using: set-associative while the cache runs direct-mapped, and direct-mapped while the cache runs set-associative. On sampled sets the block counts the hits of the real tags and the hits of the shadow tags. It compares the two counts against programmable thresholds.

When the comparison favours the other regime, the block raises a one-cycle request together with the mode it asks for. The cache then changes its mode input. The shadow store holds only tags and valid bits, never data. It is wiped whenever a request is made or the mode input changes. All counters are cleared at the end of every monitoring epoch, whose length is counted in clock cycles.

Top module: `amm_monitor`

## Requirements
- R1: While reset is low and after it is released, `switchReq` and `reqMode` are 0, and no request is made before a decision condition of R2 or R3 holds.
- R2: With `curMode`=0 (direct-mapped), once the sampled shadow hit count exceeds the sampled main hit count by more than `tUp`, `switchReq` pulses in the cycle after the access that made the counts cross. `reqMode` is 1 in that cycle.
- R3: With `curMode`=1 (set-associative), the decision is taken only on the last cycle of an epoch. A request for mode 0 is raised in the following cycle when the main hit count minus the shadow hit count is at most `tDown`. Otherwise no request is raised.
- R4: The address splits into a line offset (low `OFFSET_W` bits), a set index (next `SET_W` bits) and a tag (remaining upper bits). Only sets whose index has its low `SAMPLE_W` bits at zero are sampled. Accesses to any other set change no counter.
- R5: In set-associative emulation each sampled shadow set has `WAYS` ways. Misses fill the ways in round-robin order, so cycling `WAYS`+1 distinct tags through one set never hits, while cycling `WAYS` tags hits after the first pass.
- R6: In direct-mapped emulation the way is the low log2(`WAYS`) bits of the tag. Tags that differ only above those bits evict each other, while tags that differ in them coexist.
- R7: An epoch lasts `epochLen` cycles. At its end both hit counters return to zero.
- R8: The hit counters saturate at their all-ones value instead of wrapping.
- R9: `switchReq` is high for one cycle only, and `reqMode` is then the opposite of the mode in force when the decision was taken. After a request no further request is made until a full epoch, restarted at the request, has ended.
- R10: A request or a change of `curMode` invalidates every shadow entry and clears both counters. No hit recorded before that event counts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | A cache access is presented this cycle |
| accAddr | input | ADDR_W | Byte address of the access |
| mainHit | input | 1 | The real cache tags hit for this access |
| curMode | input | 1 | Regime in force: 0 direct-mapped, 1 set-associative |
| epochLen | input | EPOCH_W | Epoch length in cycles, held stable |
| tUp | input | CNT_W | Margin for requesting set-associative mode |
| tDown | input | CNT_W | Margin for requesting direct-mapped mode |
| switchReq | output | 1 | One-cycle request to change regime |
| reqMode | output | 1 | Mode requested with `switchReq` |

## Verification
A request for set-associative mode is due exactly one clock edge after the edge that captured the access that made the counts cross. A request for direct-mapped mode is due on edge `epochLen` after reset release or after the last clear. The bench drives at the falling edge and samples after each rising edge. It counts those edges itself from reset release and expects the pulse only on the computed edge and low on every other edge, including the edge right after a request.

// File: rtl/amm_pkg.sv
package amm_pkg;

  typedef enum logic {
    MODE_DM = 1'b0,
    MODE_SA = 1'b1
  } cache_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShadow;
    logic clearCounters;
    logic restartEpoch;
  } dp_strobe_t;

endpackage

// File: rtl/amm_shadow_tags.sv
module amm_shadow_tags #(
  parameter int TAG_W = 20,
  parameter int SS_W  = 3,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupEn,
  input  logic [SS_W-1:0]  setSel,
  input  logic [TAG_W-1:0] tagIn,
  input  logic             saMode,
  input  logic             clearAll,
  output logic             shadowHit
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int SSETS = 1 << SS_W;

  logic [TAG_W-1:0] tagMem   [SSETS][WAYS];
  logic [WAYS-1:0]  validMem [SSETS];
  logic [WAY_W-1:0] rrPtr    [SSETS];

  logic [WAYS-1:0]  wayMatch;
  logic [WAY_W-1:0] dmWay;
  logic [WAY_W-1:0] fillWay;
  logic             doFill;
  logic             anyValid;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign wayMatch[w] = validMem[setSel][w] && (tagMem[setSel][w] == tagIn);
    end
  endgenerate

  // direct-mapped emulation: low tag bits pick the way
  assign dmWay     = tagIn[WAY_W-1:0];
  assign shadowHit = saMode ? (|wayMatch) : wayMatch[dmWay];
  assign fillWay   = saMode ? rrPtr[setSel] : dmWay;
  assign doFill    = lookupEn && !shadowHit && !clearAll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SSETS; s++) begin
        validMem[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else if (clearAll) begin
      for (int s = 0; s < SSETS; s++) begin
        validMem[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else if (doFill) begin
      validMem[setSel][fillWay] <= 1'b1;
      if (saMode) rrPtr[setSel] <= rrPtr[setSel] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doFill) tagMem[setSel][fillWay] <= tagIn;
  end

  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SSETS; s++) anyValid = anyValid | (|validMem[s]);
  end

  // R10: a clear leaves no valid shadow entry behind
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clearAll |=> !anyValid);

  // R5/R6: a lookup that just filled a way hits when repeated unchanged
  p_fill_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (doFill && saMode) |=> (!lookupEn || !$stable(setSel) || !$stable(tagIn) ||
                            !$stable(saMode) || clearAll || shadowHit));

endmodule

// File: rtl/amm_datapath.sv
module amm_datapath
  import amm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SET_W    = 6,
  parameter int SAMPLE_W = 3,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 8,
  parameter int EPOCH_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               mainHit,
  input  logic               curMode,
  input  logic [EPOCH_W-1:0] epochLen,
  input  dp_strobe_t         strobe,
  output logic [CNT_W-1:0]   mainHits,
  output logic [CNT_W-1:0]   shadowHits,
  output logic               epochEnd
);

  localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;
  localparam int SS_W  = SET_W - SAMPLE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic               sampled;
  logic [SS_W-1:0]    setSel;
  logic [TAG_W-1:0]   tagIn;
  logic               shadowHit;
  logic               shadowSa;
  logic               cntClear;
  logic [EPOCH_W-1:0] epochCnt;
  logic               unusedOffsetBits;

  assign unusedOffsetBits = ^accAddr[OFFSET_W-1:0];
  assign sampled  = accValid && (accAddr[OFFSET_W +: SAMPLE_W] == '0);
  assign setSel   = accAddr[OFFSET_W+SAMPLE_W +: SS_W];
  assign tagIn    = accAddr[OFFSET_W+SET_W +: TAG_W];
  // shadow always models the regime not in force
  assign shadowSa = (cache_mode_e'(curMode) == MODE_DM);

  amm_shadow_tags #(
    .TAG_W(TAG_W),
    .SS_W (SS_W),
    .WAYS (WAYS)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .lookupEn (sampled),
    .setSel   (setSel),
    .tagIn    (tagIn),
    .saMode   (shadowSa),
    .clearAll (strobe.clearShadow),
    .shadowHit(shadowHit)
  );

  assign epochEnd = (epochCnt == epochLen - EPOCH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epochCnt <= '0;
    else if (strobe.restartEpoch || epochEnd) epochCnt <= '0;
    else epochCnt <= epochCnt + EPOCH_W'(1);
  end

  assign cntClear = strobe.clearCounters || epochEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainHits   <= '0;
      shadowHits <= '0;
    end else if (cntClear) begin
      mainHits   <= '0;
      shadowHits <= '0;
    end else if (sampled) begin
      if (mainHit && mainHits != CNT_MAX)     mainHits   <= mainHits + CNT_W'(1);
      if (shadowHit && shadowHits != CNT_MAX) shadowHits <= shadowHits + CNT_W'(1);
    end
  end

  // R8: a full counter stays full until a clear
  p_sat_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mainHits == CNT_MAX && !cntClear) |=> mainHits == CNT_MAX);
  p_sat_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shadowHits == CNT_MAX && !cntClear) |=> shadowHits == CNT_MAX);

  // R4: unsampled or absent accesses leave the counters alone
  p_unsampled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampled && !cntClear) |=> ($stable(mainHits) && $stable(shadowHits)));

  // R7: counters are empty right after an epoch ends
  p_epoch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    epochEnd |=> (mainHits == '0 && shadowHits == '0));

endmodule

// File: rtl/amm_ctrl.sv
module amm_ctrl
  import amm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             curMode,
  input  logic [CNT_W-1:0] mainHits,
  input  logic [CNT_W-1:0] shadowHits,
  input  logic             epochEnd,
  input  logic [CNT_W-1:0] tUp,
  input  logic [CNT_W-1:0] tDown,
  output dp_strobe_t       strobe,
  output logic             switchReq,
  output logic             reqMode
);

  localparam int WIDE_W = CNT_W + 1;

  cache_mode_e       modeNow;
  logic              modeSeen;
  logic              modeChanged;
  logic              holdoff;
  logic [WIDE_W-1:0] mainW;
  logic [WIDE_W-1:0] shadowW;
  logic              upCond;
  logic              downCond;
  logic              fire;

  assign modeNow     = cache_mode_e'(curMode);
  assign modeChanged = (curMode != modeSeen);
  assign mainW       = {1'b0, mainHits};
  assign shadowW     = {1'b0, shadowHits};

  assign upCond   = (modeNow == MODE_DM) && (shadowW > mainW + {1'b0, tUp});
  assign downCond = (modeNow == MODE_SA) && epochEnd && (mainW <= shadowW + {1'b0, tDown});
  assign fire     = !holdoff && !modeChanged && (upCond || downCond);

  always_comb begin
    strobe.clearShadow   = fire || modeChanged;
    strobe.clearCounters = fire || modeChanged;
    strobe.restartEpoch  = fire || modeChanged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeSeen  <= curMode;
      holdoff   <= 1'b0;
      switchReq <= 1'b0;
      reqMode   <= 1'b0;
    end else begin
      modeSeen  <= curMode;
      switchReq <= fire;
      if (fire) reqMode <= ~curMode;
      if (fire) holdoff <= 1'b1;
      else if (epochEnd) holdoff <= 1'b0;
    end
  end

  // R9: a request lasts one cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    switchReq |=> !switchReq);

  // R9: the requested mode is the other one
  p_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    switchReq |-> (reqMode != $past(curMode)));

  // R9: nothing is requested while the quiet epoch runs
  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff && !epochEnd) |=> !switchReq);

  // R10: a mode change never coincides with a new request
  p_mode_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    modeChanged |=> !switchReq);

endmodule

// File: rtl/amm_monitor.sv
module amm_monitor
  import amm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SET_W    = 6,
  parameter int SAMPLE_W = 3,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 8,
  parameter int EPOCH_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               mainHit,
  input  logic               curMode,
  input  logic [EPOCH_W-1:0] epochLen,
  input  logic [CNT_W-1:0]   tUp,
  input  logic [CNT_W-1:0]   tDown,
  output logic               switchReq,
  output logic               reqMode
);

  dp_strobe_t       strobe;
  logic [CNT_W-1:0] mainHits;
  logic [CNT_W-1:0] shadowHits;
  logic             epochEnd;

  amm_datapath #(
    .ADDR_W  (ADDR_W),
    .OFFSET_W(OFFSET_W),
    .SET_W   (SET_W),
    .SAMPLE_W(SAMPLE_W),
    .WAYS    (WAYS),
    .CNT_W   (CNT_W),
    .EPOCH_W (EPOCH_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .accAddr   (accAddr),
    .mainHit   (mainHit),
    .curMode   (curMode),
    .epochLen  (epochLen),
    .strobe    (strobe),
    .mainHits  (mainHits),
    .shadowHits(shadowHits),
    .epochEnd  (epochEnd)
  );

  amm_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .curMode   (curMode),
    .mainHits  (mainHits),
    .shadowHits(shadowHits),
    .epochEnd  (epochEnd),
    .tUp       (tUp),
    .tDown     (tDown),
    .strobe    (strobe),
    .switchReq (switchReq),
    .reqMode   (reqMode)
  );

endmodule

// File: tb/amm_monitor_test.sv
`timescale 1ns/1ps
module amm_monitor_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        accValid;
  logic [31:0] accAddr;
  logic        mainHit;
  logic        curMode;
  logic [15:0] epochLen;
  logic [7:0]  tUp;
  logic [7:0]  tDown;
  logic        switchReq;
  logic        reqMode;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  amm_monitor uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .accValid (accValid),
    .accAddr  (accAddr),
    .mainHit  (mainHit),
    .curMode  (curMode),
    .epochLen (epochLen),
    .tUp      (tUp),
    .tDown    (tDown),
    .switchReq(switchReq),
    .reqMode  (reqMode)
  );

  // tag above bit 12, set index bits 11..6, offset bits 5..0
  function automatic logic [31:0] mkAddr(input int tag, input int setIdx);
    logic [19:0] t;
    logic [5:0]  s;
    t = tag[19:0];
    s = setIdx[5:0];
    return {t, s, 6'd0};
  endfunction

  task automatic expectReq(input logic exp, input string req);
    checks++;
    if (switchReq !== exp) begin
      fails++;
      $display("FAIL %s: switchReq=%0b expected %0b at %0t", req, switchReq, exp, $time);
    end
  endtask

  task automatic expectMode(input logic exp, input string req);
    checks++;
    if (reqMode !== exp) begin
      fails++;
      $display("FAIL %s: reqMode=%0b expected %0b at %0t", req, reqMode, exp, $time);
    end
  endtask

  task automatic doReset(input logic mode, input int len, input int up, input int down);
    rst_n    = 1'b0;
    accValid = 1'b0;
    accAddr  = '0;
    mainHit  = 1'b0;
    curMode  = mode;
    epochLen = len[15:0];
    tUp      = up[7:0];
    tDown    = down[7:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input int tag, input int setIdx, input logic hit);
    accValid = 1'b1;
    accAddr  = mkAddr(tag, setIdx);
    mainHit  = hit;
    @(negedge clk);
  endtask

  task automatic idle();
    accValid = 1'b0;
    mainHit  = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    curMode = 1'b1;
    @(negedge clk);
    expectReq(1'b0, "R1 during reset");
    expectMode(1'b0, "R1 during reset");
    doReset(1'b1, 1000, 0, 0);
    for (int i = 0; i < 5; i++) begin
      idle();
      expectReq(1'b0, "R1 after reset");
    end
  endtask

  task automatic testUpSwitch();
    doReset(1'b0, 40, 3, 0);
    for (int i = 0; i < 6; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R2 before crossing");
    end
    idle();
    expectReq(1'b1, "R2 crossing");
    expectMode(1'b1, "R9 requested mode SA");
    idle();
    expectReq(1'b0, "R9 single pulse");
  endtask

  task automatic testUnsampled();
    doReset(1'b0, 1000, 3, 0);
    for (int i = 0; i < 20; i++) begin
      access((i % 2) * 4, (i < 10) ? 1 : 12, 1'b0);
      expectReq(1'b0, "R4 unsampled set");
    end
    idle();
    expectReq(1'b0, "R4 unsampled set");
    for (int i = 0; i < 6; i++) begin
      access((i % 2) * 4, 8, 1'b0);
      expectReq(1'b0, "R4 sampled set 8");
    end
    idle();
    expectReq(1'b1, "R4 sampled set 8");
  endtask

  task automatic testRoundRobin();
    doReset(1'b0, 1000, 3, 0);
    for (int i = 0; i < 15; i++) begin
      access((i % 5) * 4, 0, 1'b0);
      expectReq(1'b0, "R5 five tags thrash");
    end
    idle();
    expectReq(1'b0, "R5 five tags thrash");
    doReset(1'b0, 1000, 3, 0);
    for (int i = 0; i < 8; i++) begin
      access((i % 4) * 4, 0, 1'b0);
      expectReq(1'b0, "R5 four tags");
    end
    idle();
    expectReq(1'b1, "R5 four tags fit");
  endtask

  task automatic testDownSwitch();
    doReset(1'b1, 50, 0, 2);
    for (int i = 0; i < 10; i++) begin
      access(5, 0, 1'b1);
      expectReq(1'b0, "R3 mid epoch");
    end
    for (int e = 11; e <= 50; e++) begin
      idle();
      expectReq(e == 50, "R3 epoch end decision");
    end
    expectMode(1'b0, "R9 requested mode DM");
  endtask

  task automatic testDmCollide();
    doReset(1'b1, 50, 0, 2);
    for (int i = 0; i < 20; i++) begin
      access((i % 2) * 4, 0, 1'b1);
      expectReq(1'b0, "R6 colliding tags");
    end
    for (int e = 21; e <= 100; e++) begin
      idle();
      expectReq(e == 100, "R6/R7 stay SA then cleared epoch");
    end
  endtask

  task automatic testDmSeparate();
    doReset(1'b1, 50, 0, 2);
    for (int i = 0; i < 20; i++) begin
      access(1 + (i % 2), 0, 1'b1);
      expectReq(1'b0, "R6 separate ways");
    end
    for (int e = 21; e <= 50; e++) begin
      idle();
      expectReq(e == 50, "R6 separate ways coexist");
    end
  endtask

  task automatic testSaturate();
    doReset(1'b1, 400, 0, 0);
    for (int i = 0; i < 300; i++) access(7, 8, 1'b1);
    for (int e = 301; e <= 400; e++) begin
      idle();
      if (e >= 398) expectReq(e == 400, "R8 saturating counters");
    end
  endtask

  task automatic testHoldoff();
    doReset(1'b0, 40, 3, 0);
    for (int i = 0; i < 6; i++) access((i % 2) * 4, 0, 1'b0);
    idle();
    expectReq(1'b1, "R9 first request");
    for (int i = 0; i < 30; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R9 holdoff");
    end
    for (int i = 0; i < 10; i++) begin
      idle();
      expectReq(1'b0, "R9 holdoff");
    end
    for (int i = 0; i < 4; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R9 after holdoff");
    end
    access(0, 0, 1'b0);
    expectReq(1'b1, "R9 request after holdoff");
  endtask

  task automatic testModeClear();
    doReset(1'b0, 1000, 3, 0);
    for (int i = 0; i < 4; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R10 warm up");
    end
    accValid = 1'b0;
    curMode  = 1'b1;
    @(negedge clk);
    expectReq(1'b0, "R10 mode change");
    curMode = 1'b0;
    @(negedge clk);
    expectReq(1'b0, "R10 mode change");
    for (int i = 0; i < 4; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R10 refill");
    end
    idle();
    expectReq(1'b0, "R10 shadow cleared on mode change");
    for (int i = 0; i < 2; i++) begin
      access((i % 2) * 4, 0, 1'b0);
      expectReq(1'b0, "R10 refill");
    end
    idle();
    expectReq(1'b1, "R10 monitoring resumes");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #600000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    rst_n    = 1'b0;
    accValid = 1'b0;
    accAddr  = '0;
    mainHit  = 1'b0;
    curMode  = 1'b0;
    epochLen = 16'd1000;
    tUp      = '0;
    tDown    = '0;
    @(negedge clk);
    testReset();
    testUpSwitch();
    testUnsampled();
    testRoundRobin();
    testDownSwitch();
    testDmCollide();
    testDmSeparate();
    testSaturate();
    testHoldoff();
    testModeClear();
    finishRun();
  end

endmodule